// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This block keeps a 40-bit accumulator and a one-bit carry flag. The accumulator has a 32-bit low word and an 8-bit extension byte above it. Software-visible state is updated on a clock edge. The 32-bit low word can be loaded 16 bits at a time. Each cycle, the block can apply one of five operations: clear, left shift, arithmetic right shift, logical right shift, or a rotate through the carry flag. Each operation takes a signed immediate amount and finishes in a single cycle.

Shifts act on all 40 bits. The arithmetic right shift fills with copies of bit 39. The rotate treats the flag as bit 40 of a 41-bit ring. The low word, the extension byte and the flag are each on their own output. Left shifts and rotates are therefore the only ways to move data into the extension byte and the flag.

Top module: `acc_shift_rot_unit`

## Requirements
- R1: After reset, the low word, the extension byte and the flag are all zero.
- R2: `wr_lo_en` loads bits 15..0 of the accumulator from `wr_data[15:0]`. `wr_hi_en` loads bits 31..16 from `wr_data[31:16]`. Both may be set in the same cycle. A half that is not enabled, the extension byte and the flag keep their values.
- R3: Operation code 1 (clear) with `op_valid` sets all 40 accumulator bits to zero and leaves the flag unchanged. It wins over half-word writes in the same cycle.
- R4: When a half-word write and a shift or rotate (codes 2..5) occur in the same cycle, only the write takes effect and the flag keeps its value.
- R5: Code 2 (left shift) with an amount of 0..31 shifts all 40 bits toward bit 39 and fills with zeros. An amount of 0 leaves the value unchanged.
- R6: Code 3 (arithmetic right shift) takes amounts -1..-32, meaning a right shift by 1..32. It shifts all 40 bits and fills with copies of the old bit 39.
- R7: Code 4 (logical right shift) takes amounts -1..-32, meaning a right shift by 1..32. It fills with zeros.
- R8: Code 5 (rotate) with a positive amount n rotates the ring {flag, accumulator[39:0]} by n places toward bit 40. Result bit n-1 gets the old flag, and the flag gets the bit that lands in position 40.
- R9: Code 5 with a negative amount -m rotates the same 41-bit ring by m places toward bit 0.
- R10: Code 5 with an amount of 0 leaves the accumulator and the flag unchanged.
- R11: The state does not change in any of these cases: `op_valid` is low with no write; the code is 0, 6 or 7; a left shift gets a negative amount; a right shift gets an amount of zero or above.
- R12: Load 0x83159E24 with extension 0x00 and flag 0, then rotate by +1. The low word reads 0x062B3C48, the extension reads 0x01 and the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_lo_en | input | 1 | Load the low half of the low word |
| wr_hi_en | input | 1 | Load the high half of the low word |
| wr_data | input | 32 | Half-word write data (each half in its own lane) |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code: 0 none, 1 clear, 2 left, 3 arithmetic right, 4 logical right, 5 rotate |
| op_amt | input | 6 | Signed immediate amount, -32..31 |
| acc_lo | output | 32 | Accumulator bits 31..0 |
| acc_ext | output | 8 | Accumulator bits 39..32 |
| acc_flag | output | 1 | Carry flag, bit 40 of the rotate ring |

## Verification
The hardest case to reach from the ports is a right shift or rotate that starts from a nonzero extension byte and a set flag. Only earlier left shifts and rotates can produce that state, because half-word loads never touch those bits. The bench therefore never resets between sweep steps. It runs every operation code against every amount from -32 to 31 over several seed words, so the extension byte and the flag left behind by one step feed the next. A bench model tracks the full 41-bit state alongside.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
   typedef enum logic [2:0] {
      ACC_OP_NOP = 3'd0,
      ACC_OP_CLR = 3'd1,
      ACC_OP_SHL = 3'd2,
      ACC_OP_ASR = 3'd3,
      ACC_OP_LSR = 3'd4,
      ACC_OP_ROT = 3'd5
   } acc_op_e;
endpackage

// File: rtl/acc_shift_core.sv
module acc_shift_core
   import acc_shift_pkg::*;
#(
   parameter int ACC_W = 40,
   parameter int AMT_W = 6
) (
   input  logic [2:0]              op,
   input  logic signed [AMT_W-1:0] amt,
   input  logic [ACC_W-1:0]        acc_q,
   output logic [ACC_W-1:0]        res,
   output logic                    hit
);
   localparam int MAG_W = AMT_W + 1;

   logic [MAG_W-1:0] mag_l;
   logic [MAG_W-1:0] mag_r;
   logic             neg;

   generate
      if (AMT_W < 2) begin : g_bad_amt
         $error("acc_shift_core: AMT_W too small");
      end
   endgenerate

   always_comb begin
      neg   = amt[AMT_W-1];
      mag_l = {1'b0, amt};
      mag_r = MAG_W'(-$signed({amt[AMT_W-1], amt}));
      res   = acc_q;
      hit   = 1'b0;
      if (op == ACC_OP_SHL && !neg) begin
         res = acc_q << mag_l;
         hit = 1'b1;
      end else if (op == ACC_OP_ASR && neg) begin
         res = ACC_W'($signed(acc_q) >>> mag_r);
         hit = 1'b1;
      end else if (op == ACC_OP_LSR && neg) begin
         res = acc_q >> mag_r;
         hit = 1'b1;
      end
   end
endmodule

// File: rtl/acc_ring_rotate.sv
module acc_ring_rotate #(
   parameter int RING_W    = 41,
   parameter int AMT_W     = 6,
   parameter int ROT_STYLE = 0
) (
   input  logic signed [AMT_W-1:0] amt,
   input  logic [RING_W-1:0]       ring,
   output logic [RING_W-1:0]       rot
);
   localparam int CNT_W = $clog2(RING_W);

   logic [CNT_W-1:0] left_cnt;

   generate
      if ((1 << (AMT_W - 1)) >= RING_W) begin : g_bad_ring
         $error("acc_ring_rotate: amount range exceeds ring width");
      end
   endgenerate

   always_comb begin
      if (amt[AMT_W-1])
         left_cnt = CNT_W'(RING_W + int'(amt));
      else
         left_cnt = CNT_W'(int'(amt));
   end

   generate
      if (ROT_STYLE == 0) begin : g_shift_or
         always_comb begin
            rot = (ring << left_cnt) | (ring >> (RING_W - int'(left_cnt)));
         end
      end else begin : g_log_stages
         logic [RING_W-1:0] stage [CNT_W+1];
         assign stage[0] = ring;
         for (genvar k = 0; k < CNT_W; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stage[k+1] = left_cnt[k]
               ? {stage[k][RING_W-1-SH:0], stage[k][RING_W-1:RING_W-SH]}
               : stage[k];
         end
         assign rot = stage[CNT_W];
      end
   endgenerate
endmodule

// File: rtl/acc_shift_rot_unit.sv
module acc_shift_rot_unit
   import acc_shift_pkg::*;
#(
   parameter int LOW_W     = 32,
   parameter int EXT_W     = 8,
   parameter int AMT_W     = 6,
   parameter int ROT_STYLE = 0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_lo_en,
   input  logic                    wr_hi_en,
   input  logic [LOW_W-1:0]        wr_data,
   input  logic                    op_valid,
   input  logic [2:0]              op_sel,
   input  logic signed [AMT_W-1:0] op_amt,
   output logic [LOW_W-1:0]        acc_lo,
   output logic [EXT_W-1:0]        acc_ext,
   output logic                    acc_flag
);
   localparam int ACC_W  = LOW_W + EXT_W;
   localparam int HALF_W = LOW_W / 2;
   localparam int RING_W = ACC_W + 1;

   generate
      if (LOW_W % 2 != 0) begin : g_bad_low
         $error("acc_shift_rot_unit: LOW_W must be even");
      end
      if ((1 << (AMT_W - 1)) > LOW_W) begin : g_bad_amt
         $error("acc_shift_rot_unit: amount range exceeds low word");
      end
   endgenerate

   logic [ACC_W-1:0]  acc_q, acc_d, shift_res;
   logic              flag_q, flag_d, shift_hit;
   logic [RING_W-1:0] ring_out;
   logic              do_clr, do_wr;

   acc_shift_core #(.ACC_W(ACC_W), .AMT_W(AMT_W)) shift_i (
      .op(op_sel), .amt(op_amt), .acc_q(acc_q), .res(shift_res), .hit(shift_hit)
   );

   acc_ring_rotate #(.RING_W(RING_W), .AMT_W(AMT_W), .ROT_STYLE(ROT_STYLE)) rot_i (
      .amt(op_amt), .ring({flag_q, acc_q}), .rot(ring_out)
   );

   assign do_clr = op_valid && (op_sel == ACC_OP_CLR);
   assign do_wr  = wr_lo_en || wr_hi_en;

   always_comb begin
      acc_d  = acc_q;
      flag_d = flag_q;
      if (do_clr) begin
         acc_d = '0;
      end else if (do_wr) begin
         if (wr_lo_en) acc_d[HALF_W-1:0]     = wr_data[HALF_W-1:0];
         if (wr_hi_en) acc_d[LOW_W-1:HALF_W] = wr_data[LOW_W-1:HALF_W];
      end else if (op_valid) begin
         if (op_sel == ACC_OP_ROT) begin
            {flag_d, acc_d} = ring_out;
         end else if (shift_hit) begin
            acc_d = shift_res;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         acc_q  <= acc_d;
         flag_q <= flag_d;
      end
   end

   assign acc_lo   = acc_q[LOW_W-1:0];
   assign acc_ext  = acc_q[ACC_W-1:LOW_W];
   assign acc_flag = flag_q;

   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_sel == ACC_OP_CLR |=> acc_lo == '0 && acc_ext == '0 && $stable(acc_flag));

   assert_write_keeps_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_en || wr_hi_en) && !(op_valid && op_sel == ACC_OP_CLR) |=> $stable(acc_ext) && $stable(acc_flag));

   assert_write_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_en && wr_hi_en && !(op_valid && op_sel == ACC_OP_CLR) |=> acc_lo == $past(wr_data));

   assert_rot_zero_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_sel == ACC_OP_ROT && op_amt == '0 && !wr_lo_en && !wr_hi_en
      |=> $stable(acc_lo) && $stable(acc_ext) && $stable(acc_flag));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid && !wr_lo_en && !wr_hi_en
      |=> $stable(acc_lo) && $stable(acc_ext) && $stable(acc_flag));

   assert_flag_rot_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_sel == ACC_OP_ROT && !wr_lo_en && !wr_hi_en) |=> $stable(acc_flag));
endmodule

// File: tb/acc_shift_rot_unit_tb.sv
module acc_shift_rot_unit_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_lo_en = 1'b0, wr_hi_en = 1'b0, op_valid = 1'b0;
   logic [31:0] wr_data = '0;
   logic [2:0]  op_sel = '0;
   logic signed [5:0] op_amt = '0;
   logic [31:0] acc_lo;
   logic [7:0]  acc_ext;
   logic        acc_flag;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [39:0] m_acc = '0;
   logic        m_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_shift_rot_unit dut_i (
      .clk(clk), .rst_n(rst_n), .wr_lo_en(wr_lo_en), .wr_hi_en(wr_hi_en),
      .wr_data(wr_data), .op_valid(op_valid), .op_sel(op_sel), .op_amt(op_amt),
      .acc_lo(acc_lo), .acc_ext(acc_ext), .acc_flag(acc_flag)
   );

   task automatic model_step(input bit v, input int op, input int a,
                             input bit wl, input bit wh, input logic [31:0] d);
      logic [81:0] dbl;
      logic [40:0] ring;
      if (v && op == 1) m_acc = '0;
      else if (wl || wh) begin
         if (wl) m_acc[15:0]  = d[15:0];
         if (wh) m_acc[31:16] = d[31:16];
      end else if (v) begin
         case (op)
            2: if (a >= 0) m_acc = m_acc << a;
            3: if (a < 0) m_acc = 40'($signed(m_acc) >>> (-a));
            4: if (a < 0) m_acc = m_acc >> (-a);
            5: begin
               dbl = {m_flag, m_acc, m_flag, m_acc};
               if (a > 0) begin
                  dbl = dbl << a;
                  ring = dbl[81:41];
               end else begin
                  dbl = dbl >> (-a);
                  ring = dbl[40:0];
               end
               {m_flag, m_acc} = ring;
            end
            default: ;
         endcase
      end
   endtask

   task automatic step(input bit v, input int op, input int a,
                       input bit wl, input bit wh, input logic [31:0] d);
      op_valid = v; op_sel = 3'(op); op_amt = 6'(a);
      wr_lo_en = wl; wr_hi_en = wh; wr_data = d;
      model_step(v, op, a, wl, wh, d);
      @(negedge clk);
      op_valid = 1'b0; wr_lo_en = 1'b0; wr_hi_en = 1'b0;
   endtask

   task automatic check(input string tag);
      checks++;
      if (acc_lo !== m_acc[31:0] || acc_ext !== m_acc[39:32] || acc_flag !== m_flag) begin
         failures++;
         $display("FAIL %s: got lo=%h ext=%h flag=%b expected lo=%h ext=%h flag=%b",
                  tag, acc_lo, acc_ext, acc_flag, m_acc[31:0], m_acc[39:32], m_flag);
      end
   endtask

   function automatic string tag_for(int op, int a);
      case (op)
         1: return "R3";
         2: return (a >= 0) ? "R5" : "R11";
         3: return (a < 0) ? "R6" : "R11";
         4: return (a < 0) ? "R7" : "R11";
         5: return (a > 0) ? "R8" : ((a < 0) ? "R9" : "R10");
         default: return "R11";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] seeds [3];
      seeds[0] = 32'h83159E24; seeds[1] = 32'hD159E268; seeds[2] = 32'h9176AF36;
      repeat (2) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      // R12 worked example from reset state
      step(0, 0, 0, 1, 1, 32'h83159E24);
      step(1, 5, 1, 0, 0, '0);
      check("R12");
      checks++;
      if (acc_lo !== 32'h062B3C48 || acc_ext !== 8'h01 || acc_flag !== 1'b0) begin
         failures++;
         $display("FAIL R12: got lo=%h ext=%h flag=%b expected lo=062b3c48 ext=01 flag=0",
                  acc_lo, acc_ext, acc_flag);
      end
      // R2 single-half writes keep other half and extension
      step(1, 2, 8, 0, 0, '0);
      step(0, 0, 0, 1, 0, 32'hAAAA5555);
      check("R2");
      step(0, 0, 0, 0, 1, 32'h1234CDEF);
      check("R2");
      // R4 write beats shift and rotate
      step(1, 2, 5, 1, 0, 32'h0000BEEF);
      check("R4");
      step(1, 5, -7, 0, 1, 32'hF00D0000);
      check("R4");
      // R3 clear beats write
      step(1, 1, 0, 1, 1, 32'hFFFFFFFF);
      check("R3");
      // R11 idle cycle
      step(0, 5, 3, 0, 0, '0);
      check("R11");
      // sweep: every code, every amount, several seeds, state chained
      for (int s = 0; s < 3; s++) begin
         for (int op = 0; op < 8; op++) begin
            for (int a = -32; a < 32; a++) begin
               step(0, 0, 0, 1, 1, seeds[s] ^ (32'(a) << 11));
               check("R2");
               step(1, op, a, 0, 0, '0);
               check(tag_for(op, a));
               if (op == 5 && a != 0) begin
                  step(1, 5, a, 0, 0, '0);
                  check(tag_for(op, a));
               end
            end
         end
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule